// File: doc/BRIEF.md
# Save-RAM Window and Boot Remapper

This block is the address decoder of a cartridge that stores its game and its save data in one shared main RAM. Battery-backed save memory is not used. The host (console) address space has three regions. The cartridge image region is steered either to a boot ROM that holds the menu, or to the game image loaded into main RAM. The save region is a window whose RAM location and length are held in registers that the menu software writes. The register region holds a small control and status file. Every host write that lands inside the window sets a sticky dirty flag.

A console reset does not clear the loaded game or the save data. It only forces the cartridge region back to the menu image, so the console restarts into the menu. The menu then reads the dirty flag and chooses whether to store the save data. It clears the flag and switches the mapping back to the game, which runs again from RAM without being reloaded. The window base and size can only change while the menu mapping is active. All decoding is combinational, so a redirected access completes in the same bus cycle as a plain ROM access. The RAM controller and the file storage sit outside this block.

Top module: `savewin_remap`

## Requirements
- R1: After power-on reset (`rst_n` low), the mapping bit, the window base, the window size and the dirty flag all read back as 0.
- R2: While menu mapping is active (mapping bit 0), an access with `host_cs` high and `host_addr[15]` = 0 raises `boot_sel`, sets `boot_addr` = `host_addr[14:0]` and keeps `ram_sel` low.
- R3: While game mapping is active (mapping bit 1), an access with `host_addr[15]` = 0 raises `ram_sel` with `ram_addr` = `host_addr[14:0]` zero-extended, keeps `boot_sel` low, and resolves in the same cycle.
- R4: An access with `host_addr[15:14]` = 2'b10 and offset `host_addr[13:0]` below the size register raises `ram_sel`. `ram_addr` is set to (base << 8) + offset, modulo 2^20, in the same cycle and in either mapping.
- R5: A save-region access whose offset is at or above the size register (size 0 included) asserts no select, and a write there leaves the dirty flag clear.
- R6: A write with `ram_sel` high in the save region sets the dirty flag at the next clock edge. Writes to the cartridge region, to registers other than status, or beyond the window leave it unchanged.
- R7: The dirty flag reads at status bit 0 and stays set until a status write carries a 1 in bit 0. A status write with bit 0 = 0 has no effect.
- R8: The mapping bit is control register bit 0. A `console_rst` pulse forces menu mapping at the next edge and overrides a control write in the same cycle. It leaves base, size and dirty flag unchanged, so writing mapping bit 1 afterwards maps the same game image again.
- R9: Writes to the base register (index 1) and the size register (index 2) take effect only while menu mapping is active. In game mapping they are ignored.
- R10: `host_addr[15:14]` = 2'b11 raises `reg_sel`. `host_addr[1:0]` picks control (0), base (1), size (2) or status (3), and `host_addr[13:2]` is ignored. `reg_rdata` returns the value right-aligned and zero-extended.
- R11: At most one of `ram_sel`, `boot_sel` and `reg_sel` is high at a time. None is high while `host_cs` is low. `ram_we` = `host_cs` & `host_we` & `ram_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, synchronous |
| console_rst | input | 1 | Console reset pulse, forces menu mapping |
| host_cs | input | 1 | Host access valid this cycle |
| host_we | input | 1 | Host access is a write |
| host_addr | input | 16 | Host word address |
| host_wdata | input | 16 | Host write data |
| ram_sel | output | 1 | Access targets main RAM |
| ram_we | output | 1 | Write strobe toward main RAM |
| ram_addr | output | 20 | Translated main RAM word address |
| boot_sel | output | 1 | Access targets the boot/menu ROM |
| boot_addr | output | 15 | Boot ROM word address |
| reg_sel | output | 1 | Access targets the register file |
| reg_rdata | output | 16 | Register read data |

## Verification
The bench probes the window edges. It uses offset size-1 against offset size, a zero-size window and a base near the top of RAM where the sum wraps. A decoder with an off-by-one compare would redirect or flag a write one word past the window, and one without a truncated sum would mis-address the top block. The bench also issues console resets together with a control write and a pending dirty flag. A design that let the write win would boot straight back into the game, and one that cleared state on console reset would lose the save flag or the loaded game. Base and size writes attempted in game mode, and a status write with bit 0 clear, expose a design that leaves the window movable or clears the flag too eagerly.

// File: rtl/savewin_pkg.sv
package savewin_pkg;

   // Host address regions, decoded from the two top address bits
   typedef enum logic [1:0] {
      RGN_CART = 2'b00,
      RGN_SAVE = 2'b10,
      RGN_REGS = 2'b11
   } region_e;

   // Register indices inside the register region
   localparam logic [1:0] IDX_CTRL   = 2'd0;
   localparam logic [1:0] IDX_BASE   = 2'd1;
   localparam logic [1:0] IDX_SIZE   = 2'd2;
   localparam logic [1:0] IDX_STATUS = 2'd3;

endpackage

// File: rtl/savewin_decode.sv
module savewin_decode
   import savewin_pkg::*;
#(
   parameter int HADDR_W    = 16,
   parameter int RADDR_W    = 20,
   parameter int BASE_SHIFT = 8,
   localparam int BASE_W    = RADDR_W - BASE_SHIFT,
   localparam int OFS_W     = HADDR_W - 2,
   localparam int SIZE_W    = OFS_W + 1,
   localparam int CART_W    = HADDR_W - 1
) (
   input  logic               host_cs,
   input  logic [HADDR_W-1:0] host_addr,
   input  logic               game_map,
   input  logic [BASE_W-1:0]  base_q,
   input  logic [SIZE_W-1:0]  size_q,
   output logic               ram_sel,
   output logic [RADDR_W-1:0] ram_addr,
   output logic               boot_sel,
   output logic [CART_W-1:0]  boot_addr,
   output logic               reg_sel,
   output logic [1:0]         reg_idx,
   output logic               win_hit
);

   logic [RADDR_W-1:0] base_full;
   logic [OFS_W-1:0]   win_ofs;
   logic [CART_W-1:0]  cart_ofs;
   logic               in_cart, in_save, in_regs;

   // Window base granularity: the register holds the upper bits only
   generate
      if (BASE_SHIFT == 0) begin : g_base_flat
         assign base_full = base_q;
      end else begin : g_base_shifted
         assign base_full = {base_q, {BASE_SHIFT{1'b0}}};
      end
   endgenerate

   assign cart_ofs = host_addr[CART_W-1:0];
   assign win_ofs  = host_addr[OFS_W-1:0];
   assign in_cart  = host_cs && (host_addr[HADDR_W-1] == 1'b0);
   assign in_save  = host_cs && (host_addr[HADDR_W-1 -: 2] == RGN_SAVE);
   assign in_regs  = host_cs && (host_addr[HADDR_W-1 -: 2] == RGN_REGS);

   assign win_hit  = in_save && ({1'b0, win_ofs} < size_q);

   always_comb begin
      ram_sel   = 1'b0;
      ram_addr  = '0;
      boot_sel  = 1'b0;
      boot_addr = cart_ofs;
      if (win_hit) begin
         ram_sel  = 1'b1;
         ram_addr = base_full + RADDR_W'(win_ofs);
      end else if (in_cart) begin
         if (game_map) begin
            ram_sel  = 1'b1;
            ram_addr = RADDR_W'(cart_ofs);
         end else begin
            boot_sel = 1'b1;
         end
      end
   end

   assign reg_sel = in_regs;
   assign reg_idx = host_addr[1:0];

endmodule

// File: rtl/savewin_regs.sv
module savewin_regs
   import savewin_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int BASE_W = 12,
   parameter int SIZE_W = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              console_rst,
   input  logic              reg_wr,
   input  logic [1:0]        reg_idx,
   input  logic [DATA_W-1:0] wdata,
   input  logic              win_wr,
   output logic              game_q,
   output logic [BASE_W-1:0] base_q,
   output logic [SIZE_W-1:0] size_q,
   output logic              dirty_q,
   output logic [DATA_W-1:0] rdata
);

   logic wr_ctrl, wr_base, wr_size, clr_dirty;

   assign wr_ctrl   = reg_wr && (reg_idx == IDX_CTRL);
   assign wr_base   = reg_wr && (reg_idx == IDX_BASE) && !game_q;
   assign wr_size   = reg_wr && (reg_idx == IDX_SIZE) && !game_q;
   assign clr_dirty = reg_wr && (reg_idx == IDX_STATUS) && wdata[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         game_q <= 1'b0;
      end else if (console_rst) begin
         game_q <= 1'b0;
      end else if (wr_ctrl) begin
         game_q <= wdata[0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         size_q <= '0;
      end else begin
         if (wr_base) base_q <= wdata[BASE_W-1:0];
         if (wr_size) size_q <= wdata[SIZE_W-1:0];
      end
   end

   // Sticky dirty flag: survives console reset, cleared by software only
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dirty_q <= 1'b0;
      end else if (win_wr) begin
         dirty_q <= 1'b1;
      end else if (clr_dirty) begin
         dirty_q <= 1'b0;
      end
   end

   always_comb begin
      unique case (reg_idx)
         IDX_CTRL: rdata = DATA_W'(game_q);
         IDX_BASE: rdata = DATA_W'(base_q);
         IDX_SIZE: rdata = DATA_W'(size_q);
         default:  rdata = DATA_W'(dirty_q);
      endcase
   end

endmodule

// File: rtl/savewin_remap.sv
module savewin_remap
   import savewin_pkg::*;
#(
   parameter int HADDR_W    = 16,
   parameter int RADDR_W    = 20,
   parameter int DATA_W     = 16,
   parameter int BASE_SHIFT = 8,
   localparam int BASE_W    = RADDR_W - BASE_SHIFT,
   localparam int SIZE_W    = HADDR_W - 1,
   localparam int CART_W    = HADDR_W - 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               console_rst,
   input  logic               host_cs,
   input  logic               host_we,
   input  logic [HADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0]  host_wdata,
   output logic               ram_sel,
   output logic               ram_we,
   output logic [RADDR_W-1:0] ram_addr,
   output logic               boot_sel,
   output logic [CART_W-1:0]  boot_addr,
   output logic               reg_sel,
   output logic [DATA_W-1:0]  reg_rdata
);

   generate
      if (HADDR_W < 4) begin : g_bad_haddr
         $error("HADDR_W too small for the region map");
      end
      if (BASE_SHIFT < 0 || BASE_SHIFT >= RADDR_W) begin : g_bad_shift
         $error("BASE_SHIFT must lie inside the RAM address");
      end
      if (BASE_W > DATA_W || SIZE_W > DATA_W) begin : g_bad_data
         $error("base or size register wider than the data bus");
      end
      if (CART_W > RADDR_W) begin : g_bad_cart
         $error("game image does not fit in RAM address space");
      end
   endgenerate

   logic              game_q, dirty_q, win_hit;
   logic [BASE_W-1:0] base_q;
   logic [SIZE_W-1:0] size_q;
   logic [1:0]        reg_idx;
   logic              wr_access;

   assign wr_access = host_cs && host_we;

   savewin_decode #(
      .HADDR_W    (HADDR_W),
      .RADDR_W    (RADDR_W),
      .BASE_SHIFT (BASE_SHIFT)
   ) u_decode (
      .host_cs   (host_cs),
      .host_addr (host_addr),
      .game_map  (game_q),
      .base_q    (base_q),
      .size_q    (size_q),
      .ram_sel   (ram_sel),
      .ram_addr  (ram_addr),
      .boot_sel  (boot_sel),
      .boot_addr (boot_addr),
      .reg_sel   (reg_sel),
      .reg_idx   (reg_idx),
      .win_hit   (win_hit)
   );

   savewin_regs #(
      .DATA_W (DATA_W),
      .BASE_W (BASE_W),
      .SIZE_W (SIZE_W)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .console_rst (console_rst),
      .reg_wr      (wr_access && reg_sel),
      .reg_idx     (reg_idx),
      .wdata       (host_wdata),
      .win_wr      (wr_access && win_hit),
      .game_q      (game_q),
      .base_q      (base_q),
      .size_q      (size_q),
      .dirty_q     (dirty_q),
      .rdata       (reg_rdata)
   );

   assign ram_we = wr_access && ram_sel;

endmodule

// File: rtl/savewin_remap_chk.sv
module savewin_remap_chk #(
   parameter int HADDR_W = 16,
   parameter int DATA_W  = 16,
   parameter int BASE_W  = 12,
   parameter int SIZE_W  = 15
) (
   input logic               clk,
   input logic               rst_n,
   input logic               console_rst,
   input logic               host_cs,
   input logic               host_we,
   input logic [HADDR_W-1:0] host_addr,
   input logic [DATA_W-1:0]  host_wdata,
   input logic               ram_sel,
   input logic               ram_we,
   input logic               boot_sel,
   input logic               reg_sel,
   input logic               game_q,
   input logic               dirty_q,
   input logic [BASE_W-1:0]  base_q,
   input logic [SIZE_W-1:0]  size_q
);

   logic save_rgn, status_clear;
   assign save_rgn     = host_addr[HADDR_W-1 -: 2] == 2'b10;
   assign status_clear = host_cs && host_we && reg_sel &&
                         (host_addr[1:0] == 2'd3) && host_wdata[0];

   // R6
   a_r6_win_write_sets_dirty: assert property (@(posedge clk) disable iff (!rst_n)
      (host_cs && host_we && ram_sel && save_rgn) |=> dirty_q);

   // R7
   a_r7_dirty_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (dirty_q && !status_clear) |=> dirty_q);

   // R8
   a_r8_console_forces_menu: assert property (@(posedge clk) disable iff (!rst_n)
      console_rst |=> !game_q);

   // R9
   a_r9_window_locked_in_game: assert property (@(posedge clk) disable iff (!rst_n)
      game_q |=> ($stable(base_q) && $stable(size_q)));

   // R2
   a_r2_menu_boots_rom: assert property (@(posedge clk) disable iff (!rst_n)
      (!game_q && host_cs && !host_addr[HADDR_W-1]) |-> (boot_sel && !ram_sel));

   // R11
   a_r11_one_target: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ram_sel, boot_sel, reg_sel}));

   // R11
   a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !host_cs |-> !(ram_sel || boot_sel || reg_sel || ram_we));

endmodule

bind savewin_remap savewin_remap_chk #(
   .HADDR_W (HADDR_W),
   .DATA_W  (DATA_W),
   .BASE_W  (BASE_W),
   .SIZE_W  (SIZE_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .console_rst (console_rst),
   .host_cs     (host_cs),
   .host_we     (host_we),
   .host_addr   (host_addr),
   .host_wdata  (host_wdata),
   .ram_sel     (ram_sel),
   .ram_we      (ram_we),
   .boot_sel    (boot_sel),
   .reg_sel     (reg_sel),
   .game_q      (game_q),
   .dirty_q     (dirty_q),
   .base_q      (base_q),
   .size_q      (size_q)
);

// File: tb/savewin_remap_tb.sv
module savewin_remap_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        console_rst = 1'b0;
   logic        host_cs = 1'b0;
   logic        host_we = 1'b0;
   logic [15:0] host_addr = '0;
   logic [15:0] host_wdata = '0;
   logic        ram_sel, ram_we, boot_sel, reg_sel;
   logic [19:0] ram_addr;
   logic [14:0] boot_addr;
   logic [15:0] reg_rdata;

   int compared = 0;
   int mismatched = 0;

   // reference model state
   int m_game = 0, m_base = 0, m_size = 0, m_dirty = 0;

   always #4 clk = ~clk;   // 125 MHz

   savewin_remap u_dut (
      .clk(clk), .rst_n(rst_n), .console_rst(console_rst),
      .host_cs(host_cs), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .ram_sel(ram_sel), .ram_we(ram_we),
      .ram_addr(ram_addr), .boot_sel(boot_sel), .boot_addr(boot_addr),
      .reg_sel(reg_sel), .reg_rdata(reg_rdata)
   );

   task automatic step(input bit cs, input bit we, input int a, input int wd,
                       input bit crst, input string tag);
      int rgn, ofs, idx, ng, nb, ns, nd;
      int e_ram, e_boot, e_reg, e_we, e_ra, e_ba, e_rd;
      logic [54:0] exp_v, act_v;
      @(negedge clk);
      host_cs = cs; host_we = we; host_addr = 16'(a); host_wdata = 16'(wd);
      console_rst = crst;
      #1;
      rgn = (a >> 14) & 3; ofs = a & 16'h3FFF; idx = a & 3;
      e_ram = 0; e_boot = 0; e_reg = 0; e_ra = 0; e_ba = 0; e_rd = 0;
      if (cs) begin
         if (rgn < 2) begin
            if (m_game != 0) begin e_ram = 1; e_ra = a & 16'h7FFF; end
            else begin e_boot = 1; e_ba = a & 16'h7FFF; end
         end else if (rgn == 2) begin
            if (ofs < m_size) begin
               e_ram = 1; e_ra = (m_base * 256 + ofs) % 1048576;
            end
         end else begin
            e_reg = 1;
            case (idx)
               0: e_rd = m_game;
               1: e_rd = m_base;
               2: e_rd = m_size;
               default: e_rd = m_dirty;
            endcase
         end
      end
      e_we = (cs && we && e_ram != 0) ? 1 : 0;
      exp_v = {1'(e_ram), 1'(e_boot), 1'(e_reg), 1'(e_we), 20'(e_ra), 15'(e_ba), 16'(e_rd)};
      act_v = {ram_sel, boot_sel, reg_sel, ram_we,
               ram_sel ? ram_addr : 20'h0, boot_sel ? boot_addr : 15'h0,
               reg_sel ? reg_rdata : 16'h0};
      compared++;
      if (act_v !== exp_v) begin
         mismatched++;
         $display("FAIL %s addr=%h actual=%h expected=%h", tag, a[15:0], act_v, exp_v);
      end
      // model update at the coming edge, from the old state
      ng = m_game; nb = m_base; ns = m_size; nd = m_dirty;
      if (cs && we) begin
         if (rgn == 3) begin
            case (idx)
               0: ng = wd & 1;
               1: if (m_game == 0) nb = wd & 16'h0FFF;
               2: if (m_game == 0) ns = wd & 16'h7FFF;
               default: if ((wd & 1) != 0) nd = 0;
            endcase
         end else if (rgn == 2 && ofs < m_size) begin
            nd = 1;
         end
      end
      if (crst) ng = 0;
      @(posedge clk);
      m_game = ng; m_base = nb; m_size = ns; m_dirty = nd;
   endtask

   task automatic rd(input int a, input string tag);
      step(1, 0, a, 0, 0, tag);
   endtask

   task automatic wr(input int a, input int d, input string tag);
      step(1, 1, a, d, 0, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R1 reset state of every register
      rd(16'hC000, "R1"); rd(16'hC001, "R1"); rd(16'hC002, "R1"); rd(16'hC003, "R1");
      // R2 menu mapping of the cartridge region
      rd(16'h0000, "R2"); rd(16'h7FFF, "R2"); wr(16'h1234, 16'hAAAA, "R2");
      rd(16'hC003, "R6");  // cart write left dirty clear
      // R5 zero-size window: no select, no dirty
      wr(16'h8000, 16'h5555, "R5"); rd(16'hC003, "R5");
      // R9 base and size writable in menu mode, R10 read back
      wr(16'hC001, 16'h0123, "R9"); wr(16'hC002, 16'h0100, "R9");
      rd(16'hC001, "R10"); rd(16'hC002, "R10");
      // R5 write just past the window
      wr(16'h8100, 16'h1111, "R5"); rd(16'hC003, "R5");
      // R4 and R6 write at the last window word
      rd(16'h8000, "R4"); wr(16'h80FF, 16'h2222, "R4"); rd(16'hC003, "R6");
      // R3 game mapping
      wr(16'hC000, 16'h0001, "R8"); rd(16'hC000, "R8");
      rd(16'h0000, "R3"); rd(16'h7ABC, "R3"); wr(16'h0042, 16'h3333, "R3");
      // R9 window locked in game mode
      wr(16'hC001, 16'h0777, "R9"); wr(16'hC002, 16'h0004, "R9");
      rd(16'hC001, "R9"); rd(16'hC002, "R9"); rd(16'h8050, "R4");
      // R8 console reset forces menu, keeps dirty and window
      step(0, 0, 0, 0, 1, "R8");
      rd(16'hC000, "R8"); rd(16'hC003, "R8"); rd(16'hC001, "R8"); rd(16'h0010, "R8");
      // R8 console reset beats a simultaneous control write
      wr(16'hC000, 16'h0001, "R8");
      step(1, 1, 16'hC000, 16'h0001, 1, "R8");
      rd(16'hC000, "R8"); rd(16'h0010, "R8");
      // R7 clear only with bit0 set
      wr(16'hC003, 16'hFFFE, "R7"); rd(16'hC003, "R7");
      wr(16'hC003, 16'h0001, "R7"); rd(16'hC003, "R7");
      // R10 aliasing of the register index
      rd(16'hFFF1, "R10"); rd(16'hD5A2, "R10");
      // R4 wrap at the top of RAM with the largest window
      wr(16'hC001, 16'h0FFF, "R4"); wr(16'hC002, 16'h4000, "R4");
      rd(16'hBFFF, "R4"); rd(16'h8000, "R4");
      // R11 idle bus: no selects, no dirty from an unqualified write
      step(0, 1, 16'h8005, 16'h9999, 0, "R11"); rd(16'hC003, "R11");
      // R3 re-run of the loaded game after reset
      wr(16'hC000, 16'h0001, "R3"); rd(16'h0100, "R3");
      // random traffic against the model
      for (int i = 0; i < 400; i++) begin
         int r;
         r = int'($urandom);
         step(((r >> 20) & 7) != 0, ((r >> 23) & 1) != 0, r & 16'hFFFF,
              int'($urandom) & 16'hFFFF, ((r >> 24) & 15) == 0, "R11");
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule